// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides when an internal CPU bus master must give the external pins to an outside bus master. The outside master asks with an active-low request line. The block samples that line on every rising clock edge. Once the request has been seen low for long enough, the block hands over the bus at the next internal bus-cycle boundary. The handover is reported on an active-low acknowledge output. At the same moment the block drops the pin drive enable, so the address, data, strobe and chip-select pins float, and it raises a stall to the internal master.

A software enable bit gates the whole mechanism. The outside master has the highest priority: once it holds the bus, nothing internal can take the bus back. The bus returns only after the request has been sampled high on two edges in a row. The minimum latency and the number of high samples needed to end a release are parameters.

Top module: `ext_bus_release_arbiter`

## Requirements
- R1: After a synchronous active-high reset, ack_n is 1, pin_oe is 1 and stall is 0.
- R2: While rel_en is 0 at the sampling edges, a low req_n never starts a release. Clearing rel_en while a request is still pending discards that request.
- R3: A release starts only on a clock edge at which cyc_end is sampled 1. While cyc_end stays 0, the request keeps waiting.
- R4: Counting the first edge at which req_n is sampled low (with rel_en 1) as edge 0, the earliest release edge is edge 3. The outputs change right after that edge.
- R5: If req_n is sampled high before the release starts, the pending request is dropped. A later low sample starts the count again from edge 0.
- R6: While released, ack_n is 0, pin_oe is 0 (all bus pins high-impedance) and stall is 1.
- R7: A release ends on the second consecutive edge at which req_n is sampled high. On that edge ack_n returns to 1, pin_oe to 1 and stall to 0, together.
- R8: A single high sample of req_n followed by a low sample does not end a release. The count of consecutive high samples starts again.
- R9: While req_n is sampled low during a release, the release persists whatever cyc_end does.
- R10: Clearing rel_en during a release does not shorten it: the release still ends after two high samples. After that, requests are ignored while rel_en stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rel_en | input | 1 | Software bit allowing the bus to be released |
| req_n | input | 1 | Active-low bus request from the external master |
| cyc_end | input | 1 | High when the internal master is at a bus-cycle boundary |
| ack_n | output | 1 | Active-low acknowledge; low while the bus is released |
| pin_oe | output | 1 | Drive enable for address, data, strobe and chip-select pins; 0 means high-impedance |
| stall | output | 1 | Blocks the internal master from starting a bus cycle |

## Verification
The bench aims at the latency edge. Its model expects the release right after the fourth consecutive low sample, so a design that is one edge early or late fails at once. It also sends a lone high pulse, both before the release and during it. A design that does not drop a pending request on that pulse would grant too soon. A design that ends the release on one high sample would raise ack_n early. Further cases hold cyc_end low while a request waits, which catches a mid-cycle handover, and clear rel_en during a release. A design that reacts to the enable at once would cut the release short, and one that forgets it afterwards would grant a later request.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef enum logic {ARB_OWNED = 1'b0, ARB_RELEASED = 1'b1} arb_state_t;

  // Latency reached once the count of consecutive low samples hits the minimum.
  function automatic logic latency_met(input int unsigned lows, input int unsigned min_lat);
    return lows >= min_lat;
  endfunction

  // Release ends on the sample that completes the run of high samples.
  function automatic logic exit_due(input int unsigned highs_before, input logic req_n_s,
                                    input int unsigned need);
    return req_n_s && ((highs_before + 1) >= need);
  endfunction
endpackage

// File: rtl/ebr_latency_timer.sv
module ebr_latency_timer #(
  parameter int unsigned MIN_LAT = 3,
  localparam int unsigned CW = $clog2(MIN_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic advance,
  output logic met
);
  import ebr_pkg::*;

  logic [CW-1:0] lows;

  // Counts consecutive enabled low samples; any other sample clears it.
  always_ff @(posedge clk) begin
    if (rst || !advance) lows <= '0;
    else if (lows != CW'(MIN_LAT)) lows <= lows + 1'b1;
  end

  assign met = latency_met(32'(lows), MIN_LAT);
endmodule

// File: rtl/ebr_exit_filter.sv
module ebr_exit_filter #(
  parameter int unsigned HIGH_N = 2,
  localparam int unsigned HW = $clog2(HIGH_N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic req_n,
  output logic done
);
  import ebr_pkg::*;

  logic [HW-1:0] highs;

  // R8: a low sample restarts the run of high samples.
  always_ff @(posedge clk) begin
    if (rst || !active) highs <= '0;
    else if (req_n) highs <= highs + 1'b1;
    else highs <= '0;
  end

  assign done = active && exit_due(32'(highs), req_n, HIGH_N);
endmodule

// File: rtl/ext_bus_release_arbiter.sv
module ext_bus_release_arbiter #(
  parameter int unsigned MIN_LAT = 3,
  parameter int unsigned HIGH_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rel_en,
  input  logic req_n,
  input  logic cyc_end,
  output logic ack_n,
  output logic pin_oe,
  output logic stall
);
  import ebr_pkg::*;

  arb_state_t state;
  logic       req_valid;   // enabled low sample while the bus is still owned
  logic       lat_met;     // enough prior low samples for a release
  logic       grant_now;   // release takes effect at this edge
  logic       exit_now;    // release ends at this edge

  assign req_valid = rel_en && !req_n && (state == ARB_OWNED);

  ebr_latency_timer #(.MIN_LAT(MIN_LAT)) u_timer (
    .clk(clk), .rst(rst), .advance(req_valid), .met(lat_met)
  );

  ebr_exit_filter #(.HIGH_N(HIGH_N)) u_exit (
    .clk(clk), .rst(rst), .active(state == ARB_RELEASED), .req_n(req_n), .done(exit_now)
  );

  // R3/R4: grant only at a cycle boundary once the latency is met.
  assign grant_now = req_valid && lat_met && cyc_end;

  always_ff @(posedge clk) begin
    if (rst) state <= ARB_OWNED;
    else if (grant_now) state <= ARB_RELEASED;
    else if (exit_now) state <= ARB_OWNED;
  end

  // R6/R7: all three outputs follow the one state bit, so they move together.
  assign ack_n  = (state != ARB_RELEASED);
  assign pin_oe = (state != ARB_RELEASED);
  assign stall  = (state == ARB_RELEASED);

  // R2: with the enable off, an owned bus stays owned.
  a_r2_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
    (ack_n && !rel_en) |=> ack_n);

  // R3: a release begins only after a sampled cycle boundary.
  a_r3_boundary_only: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> $past(cyc_end));

  // R5: a high sample while owned keeps the bus owned.
  a_r5_abort_on_high: assert property (@(posedge clk) disable iff (rst)
    (ack_n && req_n) |=> ack_n);

  // R4: the request was seen low on the edges before the grant.
  if (MIN_LAT >= 3) begin : g_lat_check
    a_r4_min_latency: assert property (@(posedge clk) disable iff (rst)
      $fell(ack_n) |-> (!$past(req_n, 1) && !$past(req_n, 2) && !$past(req_n, 3)));
  end

  // R7: the acknowledge returns only after two consecutive high samples.
  a_r7_two_high_exit: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n) |-> ($past(req_n, 1) && $past(req_n, 2)));

  // R9: a low request during a release keeps the bus released.
  a_r9_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !req_n) |=> !ack_n);
endmodule

// File: tb/test_ext_bus_release_arbiter.sv
module test_ext_bus_release_arbiter;
  logic clk = 1'b0;
  logic rst, rel_en, req_n, cyc_end;
  logic ack_n, pin_oe, stall;
  int checks = 0, errors = 0;
  string phase = "R1";
  bit finished = 0;

  // Reference model state
  int lowrun = 0, highrun = 0;
  bit m_rel = 0;

  always #10 clk = ~clk;

  ext_bus_release_arbiter i_ext_bus_release_arbiter (
    .clk(clk), .rst(rst), .rel_en(rel_en), .req_n(req_n), .cyc_end(cyc_end),
    .ack_n(ack_n), .pin_oe(pin_oe), .stall(stall)
  );

  // Behavioural model updated on each rising edge from the sampled inputs.
  always @(posedge clk) begin
    if (rst) begin
      m_rel = 0; lowrun = 0; highrun = 0;
    end else if (!m_rel) begin
      if (rel_en && !req_n) begin
        if (lowrun >= 3 && cyc_end) begin m_rel = 1; highrun = 0; end
        else if (lowrun < 3) lowrun = lowrun + 1;
      end else lowrun = 0;
    end else begin
      if (req_n) begin
        highrun = highrun + 1;
        if (highrun == 2) begin m_rel = 0; lowrun = 0; highrun = 0; end
      end else highrun = 0;
    end
  end

  task automatic check(input string tag, input logic a, input logic o, input logic s,
                       input bit rel);
    checks++;
    if (a !== !rel || o !== !rel || s !== rel) begin
      errors++;
      $display("FAIL %s: ack_n=%0b pin_oe=%0b stall=%0b expected %0b %0b %0b",
               tag, a, o, s, !rel, !rel, rel);
    end
  endtask

  // Compare against the model on every falling edge, away from the active edge.
  always @(negedge clk) if (!rst && !finished) check(phase, ack_n, pin_oe, stall, m_rel);

  task automatic drive(input logic en, input logic rq, input logic ce, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rel_en = en; req_n = rq; cyc_end = ce;
    end
  endtask

  task automatic report;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected done");
    report();
  end

  initial begin
    rst = 1; rel_en = 0; req_n = 1; cyc_end = 1;
    repeat (3) @(negedge clk);
    check("R1", ack_n, pin_oe, stall, 0);          // R1 reset state
    rst = 0;
    drive(1, 1, 1, 3);

    phase = "R2"; drive(0, 0, 1, 10);               // R2 enable off
    drive(1, 0, 1, 2); drive(0, 0, 1, 1); drive(1, 0, 1, 2); drive(1, 1, 1, 2);

    // R4: exact latency, directed
    phase = "R4";
    @(negedge clk); rel_en = 1; req_n = 0; cyc_end = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R4", ack_n, pin_oe, stall, 0);
    @(posedge clk);
    @(negedge clk); check("R4", ack_n, pin_oe, stall, 1);
    phase = "R6"; drive(1, 0, 1, 4);                // R6 released outputs
    phase = "R8"; drive(1, 1, 1, 1); drive(1, 0, 1, 3); drive(1, 1, 1, 1); drive(1, 0, 0, 2);
    phase = "R9"; drive(1, 0, 0, 3); drive(1, 0, 1, 2); drive(1, 0, 0, 2);
    phase = "R7"; drive(1, 1, 1, 4);

    phase = "R3"; drive(1, 0, 0, 8); drive(1, 0, 1, 3); drive(1, 1, 0, 3);
    phase = "R5"; drive(1, 0, 1, 2); drive(1, 1, 1, 1); drive(1, 0, 1, 3);
    drive(1, 1, 1, 1); drive(1, 0, 1, 6); drive(1, 1, 1, 3);

    phase = "R10"; drive(1, 0, 1, 6); drive(0, 0, 1, 4); drive(0, 1, 1, 1);
    drive(0, 0, 1, 2); drive(0, 1, 1, 3); drive(0, 0, 1, 10); drive(0, 1, 1, 2);

    phase = "R7_mix";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      rel_en = ($urandom_range(0, 7) != 0);
      req_n = (k % 40 < 22) ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 2) != 0);
      cyc_end = $urandom_range(0, 1);
    end
    drive(1, 1, 1, 4);
    @(negedge clk);
    report();
  end
endmodule